// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures a slave FPGA over a three-wire bit-serial link. It drives an active-low program strobe, a configuration clock and a data line, all taken from one 8-bit output word. A start request carries the length of the image about to be streamed. When that length equals the one expected image size, the block runs a fixed wake-up sequence. First it drives a program pulse. It then waits for the slave's configuration memory to clear. After that it takes image bytes from a valid/ready byte stream and shifts each one out, one bit per configuration clock.

All timing comes from the system clock. The program pulse and the clear wait are given in microseconds and scaled by a cycles-per-microsecond parameter. The low and high phases of the configuration clock are each a set number of system cycles. A request whose length does not match is refused at once: an error pulse is raised and nothing is driven onto the link. A completed load leaves the link in an idle pattern and raises a one-cycle done pulse.

Top module: `cfgld_serial_loader`

## Requirements
- R1: After reset the output word is 0x10 (only bit 4 set), busy, done, error and stream ready are all low.
- R2: A start request in idle whose length differs from IMAGE_BYTES produces exactly one one-cycle error pulse. Busy stays low, the output word stays 0x10 and ready never rises.
- R3: An accepted start drives the output word to 0x00 for exactly CLK_PER_US*PULSE_US cycles, which asserts the program line (bit 7, active low).
- R4: After the pulse the word is 0x80 (program line released) for exactly CLK_PER_US*CLEAR_US cycles before stream ready first rises.
- R5: From the end of the pulse until the load ends, the program line (bit 7) stays high.
- R6: Each byte goes out least significant bit first. The data line (bit 5) value at each configuration clock (bit 6) rising edge is the next image bit.
- R7: The data line changes only while the configuration clock is low, and it holds its value across each clock rise.
- R8: With bytes always offered, every clock low phase lasts LOW_CYC cycles and every high phase lasts HIGH_CYC cycles, including at byte boundaries.
- R9: Stream ready is high only while the block waits for a byte, or in the last cycle of a byte's final high phase. It is low while bits shift, and one byte is taken per valid-and-ready cycle. If the stream stalls, the clock is held high and no bits are lost.
- R10: The cycle after the last high phase ends, the word becomes 0x10, done pulses for one cycle and busy falls in that same cycle.
- R11: A start request while busy is ignored: no second program pulse, and the load completes normally.
- R12: Busy stays high without a gap from the accepted start to the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a configuration run |
| img_len_i | input | LEN_W | Image length in bytes announced with the request |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Block accepts the stream byte this cycle |
| cfg_pins_o | output | 8 | Link word: bit 7 program (active low), bit 6 config clock, bit 5 data, bit 4 idle marker |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| err_o | output | 1 | One-cycle pulse when a request is refused for its length |

## Verification
Two events can fall in the same cycle: the expiry of a byte's final high phase, and the acceptance of the next byte. The block raises ready in that expiry cycle, so the next low phase starts with no extra clock-high cycle. The bench provokes this by holding valid high across the whole image. It then judges each high phase, which must be exactly HIGH_CYC, and the decoded bit order. A second run holds valid low for several cycles before each byte. This forces the waiting path instead, where the clock must stay high and the data must stay correct. A start pulse issued in the middle of a run checks that the request path and the running sequence do not interfere.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int PIN_PROG_N = 7;
  localparam int PIN_CCLK   = 6;
  localparam int PIN_DIN    = 5;
  localparam int PIN_IDLE   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_CLEAR,
    ST_WAIT,
    ST_LOW,
    ST_HIGH
  } ld_state_e;

  // Build the link word from the three serial lines.
  function automatic logic [7:0] pin_word(input logic prog_n, input logic cclk, input logic din);
    logic [7:0] w;
    w = '0;
    w[PIN_PROG_N] = prog_n;
    w[PIN_CCLK]   = cclk;
    w[PIN_DIN]    = din;
    return w;
  endfunction

  function automatic logic [7:0] idle_word();
    logic [7:0] w;
    w = '0;
    w[PIN_IDLE] = 1'b1;
    return w;
  endfunction

  function automatic int unsigned us_to_cycles(input int unsigned cyc_per_us, input int unsigned us);
    return cyc_per_us * us;
  endfunction

endpackage

// File: rtl/cfgld_phase_timer.sv
module cfgld_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cfgld_bit_shifter.sv
module cfgld_bit_shifter #(
  parameter int BITS = 8,
  localparam int IDX_W = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [BITS-1:1] rest_i,
  output logic            next_o,
  output logic            last_o
);
  // Holds the bits not yet driven; bit 0 of the byte goes out on load.
  logic [BITS-2:0] sr;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= rest_i;
      idx <= '0;
    end else if (shift) begin
      sr  <= {1'b0, sr[BITS-2:1]};
      idx <= idx + 1'b1;
    end
  end

  assign next_o = sr[0];
  assign last_o = (idx == IDX_W'(BITS-1));
endmodule

// File: rtl/cfgld_serial_loader.sv
module cfgld_serial_loader
  import cfgld_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int PULSE_US    = 1,
  parameter int CLEAR_US    = 100,
  parameter int LOW_CYC     = 2,
  parameter int HIGH_CYC    = 2,
  parameter int IMAGE_BYTES = 32'h133A4,
  parameter int LEN_W       = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] img_len_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic [7:0]       cfg_pins_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int PULSE_CYC = us_to_cycles(CLK_PER_US, PULSE_US);
  localparam int CLEAR_CYC = us_to_cycles(CLK_PER_US, CLEAR_US);
  localparam int MAX_A     = (PULSE_CYC > CLEAR_CYC) ? PULSE_CYC : CLEAR_CYC;
  localparam int MAX_B     = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW        = $clog2(MAX_CYC + 1);
  localparam int CNT_W     = $clog2(IMAGE_BYTES + 1);

  ld_state_e        st;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       pins_q;
  logic             busy_q, done_q, err_q;

  logic             tmr_load, tmr_exp;
  logic [TW-1:0]    tmr_val;
  logic             sh_next, sh_last;

  // Named internal events
  logic len_ok, start_ok, start_bad, bit_end, byte_end, final_byte, byte_take, enter_low;

  assign len_ok     = (img_len_i == LEN_W'(IMAGE_BYTES));
  assign start_ok   = (st == ST_IDLE) && start_i && len_ok;
  assign start_bad  = (st == ST_IDLE) && start_i && !len_ok;
  assign bit_end    = (st == ST_HIGH) && tmr_exp;
  assign byte_end   = bit_end && sh_last;
  assign final_byte = (byte_cnt == CNT_W'(IMAGE_BYTES - 1));
  assign s_ready_o  = (st == ST_WAIT) || (byte_end && !final_byte);
  assign byte_take  = s_valid_i && s_ready_o;
  assign enter_low  = byte_take || (bit_end && !sh_last);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_ok) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(PULSE_CYC - 1);
    end else if (st == ST_PULSE && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(CLEAR_CYC - 1);
    end else if (enter_low) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(LOW_CYC - 1);
    end else if (st == ST_LOW && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(HIGH_CYC - 1);
    end
  end

  cfgld_phase_timer #(.W(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  cfgld_bit_shifter #(.BITS(8)) sh_i (
    .clk(clk), .rst_n(rst_n), .load(byte_take), .shift(bit_end && !sh_last),
    .rest_i(s_data_i[7:1]), .next_o(sh_next), .last_o(sh_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pins_q   <= idle_word();
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      byte_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_ok) begin
            st       <= ST_PULSE;
            pins_q   <= pin_word(1'b0, 1'b0, 1'b0);
            busy_q   <= 1'b1;
            byte_cnt <= '0;
          end else if (start_bad) begin
            err_q <= 1'b1;
          end
        end
        ST_PULSE: if (tmr_exp) begin
          st     <= ST_CLEAR;
          pins_q <= pin_word(1'b1, 1'b0, 1'b0);
        end
        ST_CLEAR: if (tmr_exp) st <= ST_WAIT;
        ST_WAIT: if (byte_take) begin
          st     <= ST_LOW;
          pins_q <= pin_word(1'b1, 1'b0, s_data_i[0]);
        end
        ST_LOW: if (tmr_exp) begin
          st               <= ST_HIGH;
          pins_q[PIN_CCLK] <= 1'b1;
        end
        ST_HIGH: if (tmr_exp) begin
          if (!sh_last) begin
            st     <= ST_LOW;
            pins_q <= pin_word(1'b1, 1'b0, sh_next);
          end else if (final_byte) begin
            st     <= ST_IDLE;
            pins_q <= idle_word();
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
            if (byte_take) begin
              st     <= ST_LOW;
              pins_q <= pin_word(1'b1, 1'b0, s_data_i[0]);
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cfg_pins_o = pins_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       s_ready,
  input logic       byte_take,
  input logic [7:0] pins,
  input logic       busy,
  input logic       done,
  input logic       err
);
  p_din_hold_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins[6]) |-> $stable(pins[5]));

  p_din_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pins[6] && $past(pins[6])) |-> $stable(pins[5]));

  p_ready_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && pins[7]));

  p_take_starts_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> (pins[7] && !pins[6]));

  p_prog_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(pins[7])) |-> pins[7]);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pins == 8'h10 && !busy && $past(busy)));

  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && pins == 8'h10));

  p_err_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_idle_pattern_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pins == 8'h10 && !s_ready));

  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(start_i) && $past(pins) != 8'h00) |-> pins != 8'h00);
endmodule

bind cfgld_serial_loader cfgld_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_ready(s_ready_o), .byte_take(byte_take),
  .pins(cfg_pins_o), .busy(busy_o), .done(done_o), .err(err_o)
);

// File: tb/cfgld_serial_loader_tb_top.sv
module cfgld_serial_loader_tb_top;
  localparam int CPU = 4, PUS = 1, CUS = 100, LOWC = 2, HIGHC = 3, NB = 3, LW = 17;
  localparam int PULSE_EXP = CPU * PUS;
  localparam int CLEAR_EXP = CPU * CUS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, s_valid = 1'b0, s_ready, busy, done, err;
  logic [LW-1:0] len = '0;
  logic [7:0] s_data = '0, pins;
  always #2 clk = ~clk;

  cfgld_serial_loader #(.CLK_PER_US(CPU), .PULSE_US(PUS), .CLEAR_US(CUS), .LOW_CYC(LOWC),
    .HIGH_CYC(HIGHC), .IMAGE_BYTES(NB), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .img_len_i(len), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_ready_o(s_ready), .cfg_pins_o(pins), .busy_o(busy),
    .done_o(done), .err_o(err));

  int total = 0, bad = 0;
  logic [7:0] img [0:NB-1];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor sampled on the falling edge
  bit mon_en = 0, chk_hi = 1;
  int m_zero, m_clear, m_rise, m_dchg, m_lobad, m_hibad, m_lorun, m_hirun;
  int m_progbad, m_takes, m_done, m_err, m_busyrise, m_readyidle;
  logic [7:0] m_prev;
  logic m_pbusy;
  logic bitbuf [0:63];

  task automatic mon_clear();
    m_zero = 0; m_clear = 0; m_rise = 0; m_dchg = 0; m_lobad = 0; m_hibad = 0; m_lorun = 0;
    m_hirun = 0; m_progbad = 0; m_takes = 0; m_done = 0; m_err = 0; m_busyrise = 0;
    m_readyidle = 0; m_prev = pins; m_pbusy = busy;
  endtask

  always @(negedge clk) if (mon_en) begin
    if (pins == 8'h00) m_zero++;
    if (pins == 8'h80 && !s_ready && m_takes == 0 && m_zero > 0) m_clear++;
    if (pins[6] && !m_prev[6]) begin
      if (m_rise < 64) bitbuf[m_rise] = pins[5];
      m_rise++;
      if (pins[5] != m_prev[5]) m_dchg++;
      if (m_lorun != LOWC) m_lobad++;
      m_lorun = 0;
    end
    if (!pins[6] && m_prev[6]) begin
      if (chk_hi && m_hirun != HIGHC) m_hibad++;
      m_hirun = 0;
    end
    if (pins[6] && m_prev[6] && pins[5] != m_prev[5]) m_dchg++;
    if (m_pbusy && busy && m_zero > 0 && !pins[7] && m_prev[7]) m_progbad++;
    if (busy && !m_pbusy) m_busyrise++;
    if (pins[7] && !pins[6] && busy && m_takes > 0) m_lorun++;
    if (pins[6]) m_hirun++;
    if (s_ready && s_valid) m_takes++;
    if (done) m_done++;
    if (err) m_err++;
    if (s_ready && !busy) m_readyidle++;
    m_prev = pins;
    m_pbusy = busy;
  end

  task automatic pulse_start(input int l);
    @(posedge clk); #1 start = 1'b1; len = LW'(l);
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic feed(input bit stall);
    for (int k = 0; k < NB; k++) begin
      if (stall) begin
        s_valid = 1'b0;
        repeat (7) @(posedge clk);
        #1;
      end
      s_valid = 1'b1; s_data = img[k];
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1 s_valid = 1'b0;
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R10", "done reached", done, 1);
    check(pins == 8'h10, "R10", "idle word at done", pins, 8'h10);
    check(busy == 1'b0, "R10", "busy falls with done", busy, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_bits(input string tag);
    int errs = 0;
    for (int k = 0; k < NB; k++)
      for (int i = 0; i < 8; i++)
        if (bitbuf[k*8+i] !== img[k][i]) errs++;
    check(m_rise == NB*8, "R6", {tag, " clock rises"}, m_rise, NB*8);
    check(errs == 0, "R6", {tag, " LSB-first bits wrong"}, errs, 0);
    check(m_takes == NB, "R9", {tag, " bytes taken"}, m_takes, NB);
    check(m_dchg == 0, "R7", {tag, " data moves with clock high"}, m_dchg, 0);
    check(m_progbad == 0, "R5", {tag, " program line dropped"}, m_progbad, 0);
    check(m_done == 1, "R10", {tag, " done pulses"}, m_done, 1);
    check(m_busyrise == 1, "R12", {tag, " busy rises"}, m_busyrise, 1);
    check(m_readyidle == 0, "R9", {tag, " ready while idle"}, m_readyidle, 0);
  endtask

  task automatic t_reset();
    check(pins == 8'h10, "R1", "reset word", pins, 8'h10);
    check(!busy, "R1", "reset busy", busy, 0);
    check(!done, "R1", "reset done", done, 0);
    check(!err, "R1", "reset err", err, 0);
    check(!s_ready, "R1", "reset ready", s_ready, 0);
  endtask

  task automatic t_bad_len(input int l);
    mon_clear(); mon_en = 1;
    pulse_start(l);
    repeat (20) @(negedge clk);
    mon_en = 0;
    check(m_err == 1, "R2", "error pulses", m_err, 1);
    check(m_busyrise == 0 && !busy, "R2", "busy after refusal", m_busyrise, 0);
    check(m_zero == 0 && pins == 8'h10, "R2", "link word touched", pins, 8'h10);
    check(m_takes == 0 && m_readyidle == 0, "R2", "ready after refusal", m_readyidle, 0);
  endtask

  task automatic t_load_stream();
    img[0] = 8'hA5; img[1] = 8'h01; img[2] = 8'h3C;
    chk_hi = 1; mon_clear(); mon_en = 1;
    fork pulse_start(NB); feed(1'b0); join
    wait_done();
    mon_en = 0;
    check(m_zero == PULSE_EXP, "R3", "program pulse cycles", m_zero, PULSE_EXP);
    check(m_clear == CLEAR_EXP, "R4", "clear wait cycles", m_clear, CLEAR_EXP);
    check(m_lobad == 0, "R8", "low phases off length", m_lobad, 0);
    check(m_hibad == 0, "R8", "high phases off length (back-to-back bytes)", m_hibad, 0);
    check_bits("stream");
  endtask

  task automatic t_load_stall();
    img[0] = 8'h80; img[1] = 8'hFE; img[2] = 8'h5A;
    chk_hi = 0; mon_clear(); mon_en = 1;
    fork pulse_start(NB); feed(1'b1); join
    wait_done();
    mon_en = 0;
    check(m_lobad == 0, "R8", "low phases with stalls", m_lobad, 0);
    check_bits("stall");
  endtask

  task automatic t_restart_ignored();
    img[0] = 8'h0F; img[1] = 8'hC3; img[2] = 8'h77;
    chk_hi = 1; mon_clear(); mon_en = 1;
    fork
      pulse_start(NB);
      feed(1'b0);
      begin repeat (30) @(posedge clk); pulse_start(NB); repeat (380) @(posedge clk); pulse_start(NB); end
    join
    wait_done();
    mon_en = 0;
    check(m_zero == PULSE_EXP, "R11", "second program pulse", m_zero, PULSE_EXP);
    check(m_err == 0, "R11", "error while busy", m_err, 0);
    check_bits("restart");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_len(NB + 1);
    t_bad_len(NB - 1);
    t_load_stream();
    t_load_stall();
    t_restart_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule